// File: doc/BRIEF.md
# Interruptible Repeated Byte-Copy Engine

This block moves a run of bytes from one memory region to another, one byte at a time, under the control of three architectural registers: a source pointer, a destination pointer and a remaining count. A start pulse loads the three registers and a direction bit. Each element is copied in two steps: a read at the source pointer, then a write of that byte at the destination pointer. Both use a request/acknowledge byte memory port. The registers are committed as soon as the write is acknowledged, so at every element boundary they describe exactly the work that is still left.

After each committed element the engine decides what to do next. If the count has reached zero, it pulses `done` and goes idle. Otherwise, if an interrupt is pending or single-step mode is on, it pulses `halted` and goes idle with the registers left where they are. Otherwise it starts the next element. Software resumes an interrupted copy by starting the engine again with the values it reads from `cur_src`, `cur_dst` and `cur_cnt`. An element is never split: an interrupt only takes effect between two elements.

The controller states are IDLE, READ, WRITE, DECIDE, FINISH and HALT. The transitions are:
- IDLE→READ on a start with a nonzero count.
- IDLE→FINISH on a start with a zero count.
- READ→WRITE when the read is acknowledged.
- WRITE→DECIDE when the write is acknowledged; the commit happens here.
- DECIDE→FINISH when the count is zero.
- DECIDE→HALT when an interrupt is pending or single-step is on.
- DECIDE→READ otherwise.
- FINISH→IDLE and HALT→IDLE unconditionally.

Top module: `rep_copy_engine`

## Requirements
- R1: Each acknowledged write commits the element: the source and destination pointers move by one and the count drops by one. No register changes at any other time while the engine is busy.
- R2: An element is a read at the source pointer (`mem_we`=0), followed by a write at the destination pointer (`mem_we`=1) of the byte just read. A request stays asserted, with address and direction unchanged, until it is acknowledged.
- R3: `irq_pend` is sampled only in DECIDE, after the write has been acknowledged. A request raised during an element lets that element finish and then stops the engine, with `halted` high for one cycle and a nonzero count left.
- R4: With `step_en`=1 the engine stops after every element. A copy of N bytes therefore takes N starts: the first N-1 end in `halted` and the last ends in `done`.
- R5: Starting again with the `cur_src`, `cur_dst` and `cur_cnt` values left after a stop copies exactly the remaining bytes. Progress already made is kept, so the total number of writes equals the original count.
- R6: A start with a count of zero raises `done` in the next cycle and issues no memory request.
- R7: `dir_down`=0 makes both pointers increment per element; `dir_down`=1 makes both decrement. The direction is captured at start.
- R8: `done` is a one-cycle pulse, raised when the count has reached zero, and the engine then returns to idle. `done` and `halted` are never high together. A zero count takes priority over a pending stop request.
- R9: A start pulse while `busy`=1 is ignored: the copy in progress and its final registers are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load registers and begin (ignored while busy) |
| init_src | input | ADDR_W | Initial source pointer |
| init_dst | input | ADDR_W | Initial destination pointer |
| init_cnt | input | CNT_W | Initial element count |
| dir_down | input | 1 | 1: pointers decrement, 0: increment |
| irq_pend | input | 1 | Interrupt pending, sampled between elements |
| step_en | input | 1 | Stop after every element |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack on a read |
| mem_ack | input | 1 | Request accepted/completed |
| cur_src | output | ADDR_W | Current source pointer |
| cur_dst | output | ADDR_W | Current destination pointer |
| cur_cnt | output | CNT_W | Remaining count |
| busy | output | 1 | Engine not idle |
| done | output | 1 | One-cycle pulse: copy complete |
| halted | output | 1 | One-cycle pulse: stopped with work left |

## Verification
Uninterrupted copies are run upward and downward. Comparing their destination bytes and final pointers separates the two pointer directions, and counting writes separates a correct copy from a duplicated or skipped element. An interrupt held from the start stops the copy after exactly one element. An interrupt raised while a read is outstanding shows that the element in flight still completes. In both cases a resume from the reported registers must finish the copy with no rewritten bytes. A single-step run needs one start per byte. A zero-count start must give an immediate `done` with no traffic. A stray start mid-copy must leave the result unchanged.

// File: rtl/rce_pkg.sv
package rce_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DECIDE,
        ST_FINISH,
        ST_HALT
    } rce_state_e;
endpackage

// File: rtl/rce_arch_regs.sv
module rce_arch_regs #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] init_src,
    input  logic [ADDR_W-1:0] init_dst,
    input  logic [CNT_W-1:0]  init_cnt,
    input  logic              init_down,
    input  logic              commit,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [CNT_W-1:0]  cnt,
    output logic              cnt_zero
);
    localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0]  ONE_C = {{(CNT_W-1){1'b0}}, 1'b1};

    logic              down_q;
    logic [ADDR_W-1:0] src_nxt;
    logic [ADDR_W-1:0] dst_nxt;

    always_comb begin
        if (down_q) begin
            src_nxt = src - ONE_A;
            dst_nxt = dst - ONE_A;
        end else begin
            src_nxt = src + ONE_A;
            dst_nxt = dst + ONE_A;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src    <= '0;
            dst    <= '0;
            cnt    <= '0;
            down_q <= 1'b0;
        end else if (load) begin
            src    <= init_src;
            dst    <= init_dst;
            cnt    <= init_cnt;
            down_q <= init_down;
        end else if (commit) begin
            src <= src_nxt;
            dst <= dst_nxt;
            cnt <= cnt - ONE_C;
        end
    end

    assign cnt_zero = (cnt == '0);
endmodule

// File: rtl/rce_mem_port.sv
module rce_mem_port
    import rce_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rce_state_e        state,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rd_done,
    output logic              wr_done
);
    logic [DATA_W-1:0] byte_q;

    always_comb begin
        mem_req  = (state == ST_READ) || (state == ST_WRITE);
        mem_we   = (state == ST_WRITE);
        mem_addr = (state == ST_WRITE) ? dst : src;
        rd_done  = (state == ST_READ)  && mem_ack;
        wr_done  = (state == ST_WRITE) && mem_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (rd_done) begin
            byte_q <= mem_rdata;
        end
    end

    assign mem_wdata = byte_q;
endmodule

// File: rtl/rce_ctrl.sv
module rce_ctrl
    import rce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       init_zero,
    input  logic       rd_done,
    input  logic       wr_done,
    input  logic       cnt_zero,
    input  logic       irq_pend,
    input  logic       step_en,
    output rce_state_e state,
    output logic       load,
    output logic       commit,
    output logic       busy,
    output logic       done,
    output logic       halted
);
    rce_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start) state_nxt = init_zero ? ST_FINISH : ST_READ;
            ST_READ:   if (rd_done) state_nxt = ST_WRITE;
            ST_WRITE:  if (wr_done) state_nxt = ST_DECIDE;
            ST_DECIDE: begin
                if (cnt_zero)                 state_nxt = ST_FINISH;
                else if (irq_pend || step_en) state_nxt = ST_HALT;
                else                          state_nxt = ST_READ;
            end
            ST_FINISH: state_nxt = ST_IDLE;
            ST_HALT:   state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        load   = (state == ST_IDLE) && start;
        commit = wr_done;
        busy   = (state != ST_IDLE);
        done   = (state == ST_FINISH);
        halted = (state == ST_HALT);
    end
endmodule

// File: rtl/rep_copy_engine.sv
module rep_copy_engine
    import rce_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] init_src,
    input  logic [ADDR_W-1:0] init_dst,
    input  logic [CNT_W-1:0]  init_cnt,
    input  logic              dir_down,
    input  logic              irq_pend,
    input  logic              step_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              busy,
    output logic              done,
    output logic              halted
);
    rce_state_e state;
    logic       load;
    logic       commit;
    logic       cnt_zero;
    logic       rd_done;
    logic       wr_done;

    rce_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .init_zero (init_cnt == '0),
        .rd_done   (rd_done),
        .wr_done   (wr_done),
        .cnt_zero  (cnt_zero),
        .irq_pend  (irq_pend),
        .step_en   (step_en),
        .state     (state),
        .load      (load),
        .commit    (commit),
        .busy      (busy),
        .done      (done),
        .halted    (halted)
    );

    rce_arch_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .init_src  (init_src),
        .init_dst  (init_dst),
        .init_cnt  (init_cnt),
        .init_down (dir_down),
        .commit    (commit),
        .src       (cur_src),
        .dst       (cur_dst),
        .cnt       (cur_cnt),
        .cnt_zero  (cnt_zero)
    );

    rce_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .src       (cur_src),
        .dst       (cur_dst),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rd_done   (rd_done),
        .wr_done   (wr_done)
    );
endmodule

// File: rtl/rce_checker.sv
module rce_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CNT_W-1:0]  init_cnt,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] cur_src,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic              done,
    input logic              halted
);
    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && (cur_cnt != $past(cur_cnt))) |-> (cur_cnt == $past(cur_cnt) - 1'b1));

    // R1
    ptr_with_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> ((cur_src != $past(cur_src)) == (cur_cnt != $past(cur_cnt))));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R3
    halt_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (cur_cnt != '0));

    // R6
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (init_cnt == '0)) |=> (done && !mem_req));

    // R8
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cur_cnt == '0));

    // R8
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && halted));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind rep_copy_engine rce_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .init_cnt (init_cnt),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .cur_src  (cur_src),
    .cur_cnt  (cur_cnt),
    .done     (done),
    .halted   (halted)
);

// File: tb/rep_copy_engine_tb_top.sv
`timescale 1ns/1ps
module rep_copy_engine_tb_top;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] init_src = '0;
    logic [AW-1:0] init_dst = '0;
    logic [CW-1:0] init_cnt = '0;
    logic          dir_down = 1'b0;
    logic          irq_pend = 1'b0;
    logic          step_en = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic [AW-1:0] cur_src, cur_dst;
    logic [CW-1:0] cur_cnt;
    logic          busy, done, halted;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int cyc = 0;
    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];

    always #4 clk = ~clk;

    rep_copy_engine #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .init_src(init_src), .init_dst(init_dst), .init_cnt(init_cnt),
        .dir_down(dir_down), .irq_pend(irq_pend), .step_en(step_en),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
        .busy(busy), .done(done), .halted(halted)
    );

    // byte memory model: acknowledges one cycle after a request is seen
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[7:0]];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d cycles exp<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'((i * 37 + 11) ^ 8'h5a);
            ref_mem[i] = 8'((i * 37 + 11) ^ 8'h5a);
        end
    endtask

    task automatic ref_copy(input int s, input int d, input int n, input bit down);
        for (int k = 0; k < n; k++) begin
            if (down) ref_mem[(d - k) & 255] = ref_mem[(s - k) & 255];
            else      ref_mem[(d + k) & 255] = ref_mem[(s + k) & 255];
        end
    endtask

    task automatic cmp_mem(input string tag);
        int errs = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != ref_mem[i]) errs++;
        check(tag, errs, 0);
    endtask

    task automatic kick(input int s, input int d, input int n, input bit down);
        @(negedge clk);
        init_src = AW'(s); init_dst = AW'(d); init_cnt = CW'(n); dir_down = down;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // returns 1 on done, 2 on halted, 0 on timeout
    task automatic wait_end(output int how);
        how = 0;
        for (int t = 0; t < 2000; t++) begin
            if (done)   begin how = 1; return; end
            if (halted) begin how = 2; return; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R8 reset done", int'(done), 0);
        check("R8 reset halted", int'(halted), 0);
        check("R2 reset req", int'(mem_req), 0);
        check("R9 reset busy", int'(busy), 0);
    endtask

    task automatic t_copy_up();
        int how, w0;
        fill_mem(); w0 = wr_cnt;
        kick(8'h10, 8'h40, 5, 1'b0);
        wait_end(how);
        ref_copy(8'h10, 8'h40, 5, 1'b0);
        check("R8 up ends done", how, 1);
        check("R1 up src", int'(cur_src), 8'h15);
        check("R1 up dst", int'(cur_dst), 8'h45);
        check("R1 up cnt", int'(cur_cnt), 0);
        @(negedge clk);
        check("R8 done pulse one cycle", int'(done), 0);
        check("R2 up writes", wr_cnt - w0, 5);
        cmp_mem("R2 up memory");
    endtask

    task automatic t_copy_down();
        int how;
        fill_mem();
        kick(8'h80, 8'hC0, 4, 1'b1);
        wait_end(how);
        ref_copy(8'h80, 8'hC0, 4, 1'b1);
        check("R7 down ends done", how, 1);
        check("R7 down src", int'(cur_src), 8'h7C);
        check("R7 down dst", int'(cur_dst), 8'hBC);
        @(negedge clk);
        cmp_mem("R7 down memory");
    endtask

    task automatic t_zero();
        int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        kick(8'h20, 8'h30, 0, 1'b0);
        check("R6 zero done next cycle", int'(done), 1);
        check("R6 zero no req", int'(mem_req), 0);
        @(negedge clk); @(negedge clk);
        check("R6 zero no traffic", (wr_cnt - w0) + (rd_cnt - r0), 0);
    endtask

    task automatic t_irq_resume();
        int how, w0;
        fill_mem(); w0 = wr_cnt;
        irq_pend = 1'b1;
        kick(8'h00, 8'h60, 6, 1'b0);
        wait_end(how);
        check("R3 irq ends halted", how, 2);
        check("R3 irq one element", wr_cnt - w0, 1);
        check("R1 irq cnt", int'(cur_cnt), 5);
        check("R1 irq src", int'(cur_src), 8'h01);
        irq_pend = 1'b0;
        @(negedge clk);
        kick(int'(cur_src), int'(cur_dst), int'(cur_cnt), 1'b0);
        wait_end(how);
        ref_copy(8'h00, 8'h60, 6, 1'b0);
        check("R5 resume ends done", how, 1);
        @(negedge clk);
        check("R5 resume total writes", wr_cnt - w0, 6);
        cmp_mem("R5 resume memory");
    endtask

    task automatic t_irq_mid();
        int how, w0;
        fill_mem(); w0 = wr_cnt;
        kick(8'h90, 8'hA0, 4, 1'b0);
        check("R3 read outstanding", int'(mem_req && !mem_we), 1);
        irq_pend = 1'b1;
        wait_end(how);
        check("R3 mid irq halted", how, 2);
        check("R3 mid element finished", wr_cnt - w0, 1);
        check("R3 mid cnt", int'(cur_cnt), 3);
        irq_pend = 1'b0;
        @(negedge clk);
        kick(int'(cur_src), int'(cur_dst), int'(cur_cnt), 1'b0);
        wait_end(how);
        ref_copy(8'h90, 8'hA0, 4, 1'b0);
        @(negedge clk);
        cmp_mem("R5 mid resume memory");
    endtask

    task automatic t_step();
        int how, stops, dones, w0;
        fill_mem(); w0 = wr_cnt; stops = 0; dones = 0;
        step_en = 1'b1;
        kick(8'h50, 8'hE0, 3, 1'b0);
        for (int k = 0; k < 3; k++) begin
            wait_end(how);
            if (how == 2) stops++;
            if (how == 1) dones++;
            @(negedge clk);
            if (how == 2) kick(int'(cur_src), int'(cur_dst), int'(cur_cnt), 1'b0);
        end
        step_en = 1'b0;
        ref_copy(8'h50, 8'hE0, 3, 1'b0);
        check("R4 step halts", stops, 2);
        check("R4 step dones", dones, 1);
        check("R4 step writes", wr_cnt - w0, 3);
        cmp_mem("R4 step memory");
    endtask

    task automatic t_start_busy();
        int how;
        fill_mem();
        kick(8'h20, 8'h70, 5, 1'b0);
        @(negedge clk);
        init_src = 16'h0003; init_dst = 16'h00F0; init_cnt = 16'd2; dir_down = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end(how);
        ref_copy(8'h20, 8'h70, 5, 1'b0);
        check("R9 busy start ignored end", how, 1);
        check("R9 busy start src", int'(cur_src), 8'h25);
        @(negedge clk);
        cmp_mem("R9 busy start memory");
    endtask

    initial begin
        fill_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_copy_up();
        t_copy_down();
        t_zero();
        t_irq_resume();
        t_irq_mid();
        t_step();
        t_start_busy();
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule